// File: doc/BRIEF.md
# Differential Pair Decoder with Integrity Check

This block turns one two-wire complementary signal into a single-ended level. A pair is usable only while its two wires disagree; the positive wire then gives the level. Each change of the decoded level produces a one-cycle pulse: a rising pulse, a falling pulse, and a general change pulse that fires for either direction. When both wires carry the same value, the block raises an integrity flag.

A build-time switch picks one of two modes. In synchronous mode the wires are sampled directly, and a single equal sample raises the flag. In asynchronous mode each wire first passes through its own chain of synchronizer flops. Because the two wires may then cross the clock boundary one cycle apart, a single equal sample is treated as skew rather than as a fault. During that sample the previous level is held, and the change is reported only once both wires have moved. A fault is declared only after two consecutive equal samples.

Top module: `diff_pair_decoder`

## Requirements
- R1: `level_o` follows the positive wire whenever the wires differ and holds its value while they are equal. In synchronous mode it updates at the clock edge that samples the inputs. In asynchronous mode with two synchronizer stages it updates two edges later.
- R2: `rise_o` is a one-cycle pulse that accompanies every 0-to-1 update of `level_o` taken from a valid sample.
- R3: `fall_o` is a one-cycle pulse that accompanies every 1-to-0 update of `level_o` taken from a valid sample.
- R4: `event_o` pulses in exactly the cycles in which `rise_o` or `fall_o` pulses.
- R5: In synchronous mode, `sigint_o` is high in the cycle after an edge at which both wires were sampled equal, and low after an edge that samples differing wires.
- R6: In asynchronous mode, `sigint_o` rises only after two consecutive synchronized samples are equal. It stays high while they remain equal and clears on the first differing sample.
- R7: In asynchronous mode, a single equal synchronized sample between two valid ones raises no flag, holds the level, and reports the change once both wires have moved.
- R8: No rise, fall or change pulse is produced while `sigint_o` is high. The first valid sample after a fault loads its level silently, with no pulse.
- R9: Synchronous active-high reset clears the level to 0, deasserts `sigint_o` and all pulses, and loads every synchronizer flop with the idle pair p=0, n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pair_p_i | input | 1 | Positive wire of the pair |
| pair_n_i | input | 1 | Negative wire of the pair |
| level_o | output | 1 | Decoded level |
| rise_o | output | 1 | Pulse on a 0-to-1 level change |
| fall_o | output | 1 | Pulse on a 1-to-0 level change |
| event_o | output | 1 | Pulse on any level change |
| sigint_o | output | 1 | Integrity fault flag (wires equal) |

## Verification
Integrity detection and edge-pulse generation can fall in the same cycle. This happens when a valid sample with a new level arrives right after an equal sample: depending on the history, that equal sample was either tolerated skew, which must yield a pulse, or the tail of a fault, which must yield none. The bench provokes every such meeting by driving all 256 four-symbol sequences of the wire pair back to back into a synchronous and an asynchronous instance. Each output is compared against a cycle-accurate model built from the requirements. Directed skewed transitions and a fault followed by recovery are then applied and judged the same way.

// File: rtl/diffdec_pkg.sv
package diffdec_pkg;

    typedef struct packed {
        logic p;
        logic n;
    } wire_pair_t;

    typedef struct packed {
        logic level;
        logic sigint;
        logic valid;
    } decode_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic change;
    } edge_pulses_t;

    localparam wire_pair_t PAIR_IDLE = '{p: 1'b0, n: 1'b1};

    function automatic logic pair_usable(input wire_pair_t w);
        return w.p ^ w.n;
    endfunction

endpackage

// File: rtl/diffdec_sync_stage.sv
module diffdec_sync_stage
    import diffdec_pkg::*;
#(
    parameter bit          ENABLE = 1'b1,
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  wire_pair_t d_i,
    output wire_pair_t q_o
);

    generate
        if (ENABLE) begin : g_sync
            wire_pair_t chain [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) chain[i] <= PAIR_IDLE;
                end else begin
                    chain[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
                end
            end

            assign q_o = chain[STAGES-1];
        end else begin : g_bypass
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/diffdec_level_core.sv
module diffdec_level_core
    import diffdec_pkg::*;
#(
    parameter bit SKEW_TOLERANT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  wire_pair_t    pair_i,
    output decode_state_t state_o
);

    logic valid_now;
    logic equal_now;
    logic fault_now;
    logic level_q;
    logic sigint_q;

    assign valid_now = pair_usable(pair_i);
    assign equal_now = ~valid_now;

    generate
        if (SKEW_TOLERANT) begin : g_two_sample
            logic equal_q;

            always_ff @(posedge clk) begin
                if (rst) equal_q <= 1'b0;
                else     equal_q <= equal_now;
            end

            assign fault_now = equal_now & equal_q;

            // R6
            two_equal_flags_chk: assert property (@(posedge clk) disable iff (rst)
                (equal_now && equal_q) |=> sigint_q);

            // R7
            single_equal_tolerated_chk: assert property (@(posedge clk) disable iff (rst)
                (equal_now && !equal_q) |=> !sigint_q);
        end else begin : g_one_sample
            assign fault_now = equal_now;

            // R5
            equal_flags_next_chk: assert property (@(posedge clk) disable iff (rst)
                equal_now |=> sigint_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= 1'b0;
            sigint_q <= 1'b0;
        end else begin
            sigint_q <= fault_now;
            if (valid_now) level_q <= pair_i.p;
        end
    end

    assign state_o = '{level: level_q, sigint: sigint_q, valid: valid_now};

    // R1
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_now |=> $stable(level_q));

endmodule

// File: rtl/diffdec_edge_gen.sv
module diffdec_edge_gen
    import diffdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wire_pair_t    pair_i,
    input  decode_state_t state_i,
    output edge_pulses_t  pulses_o
);

    logic         moved;
    edge_pulses_t pulses_q;

    assign moved = state_i.valid & (pair_i.p != state_i.level) & ~state_i.sigint;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses_q <= '0;
        end else begin
            pulses_q.rise   <= moved & pair_i.p;
            pulses_q.fall   <= moved & ~pair_i.p;
            pulses_q.change <= moved;
        end
    end

    assign pulses_o = pulses_q;

    // R4
    change_matches_edges_chk: assert property (@(posedge clk) disable iff (rst)
        pulses_q.change == (pulses_q.rise | pulses_q.fall));

    // R8
    quiet_during_fault_chk: assert property (@(posedge clk) disable iff (rst)
        state_i.sigint |=> !pulses_q.change);

    // R2
    rise_high_level_chk: assert property (@(posedge clk) disable iff (rst)
        pulses_q.rise |-> state_i.level);

    // R3
    fall_low_level_chk: assert property (@(posedge clk) disable iff (rst)
        pulses_q.fall |-> !state_i.level);

endmodule

// File: rtl/diff_pair_decoder.sv
module diff_pair_decoder
    import diffdec_pkg::*;
#(
    parameter bit          ASYNC_MODE  = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pair_p_i,
    input  logic pair_n_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o,
    output logic event_o,
    output logic sigint_o
);

    wire_pair_t    raw_pair;
    wire_pair_t    sampled_pair;
    decode_state_t dec_state;
    edge_pulses_t  pulses;

    assign raw_pair = '{p: pair_p_i, n: pair_n_i};

    diffdec_sync_stage #(
        .ENABLE (ASYNC_MODE),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (raw_pair),
        .q_o (sampled_pair)
    );

    diffdec_level_core #(
        .SKEW_TOLERANT (ASYNC_MODE)
    ) core_i (
        .clk     (clk),
        .rst     (rst),
        .pair_i  (sampled_pair),
        .state_o (dec_state)
    );

    diffdec_edge_gen edges_i (
        .clk      (clk),
        .rst      (rst),
        .pair_i   (sampled_pair),
        .state_i  (dec_state),
        .pulses_o (pulses)
    );

    assign level_o  = dec_state.level;
    assign sigint_o = dec_state.sigint;
    assign rise_o   = pulses.rise;
    assign fall_o   = pulses.fall;
    assign event_o  = pulses.change;

endmodule

// File: tb/diff_pair_decoder_tb_top.sv
module diff_pair_decoder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_p = 1'b0;
    logic in_n = 1'b1;
    bit   done = 1'b0;

    int tests_run = 0;
    int tests_failed = 0;

    always #2 clk = ~clk;

    logic a_lvl, a_rise, a_fall, a_evt, a_sig;
    logic s_lvl, s_rise, s_fall, s_evt, s_sig;

    diff_pair_decoder #(.ASYNC_MODE(1'b1), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .pair_p_i(in_p), .pair_n_i(in_n),
        .level_o(a_lvl), .rise_o(a_rise), .fall_o(a_fall),
        .event_o(a_evt), .sigint_o(a_sig)
    );

    diff_pair_decoder #(.ASYNC_MODE(1'b0), .SYNC_STAGES(2)) dut_s_i (
        .clk(clk), .rst(rst), .pair_p_i(in_p), .pair_n_i(in_n),
        .level_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall),
        .event_o(s_evt), .sigint_o(s_sig)
    );

    // model state, index 0 = asynchronous instance, 1 = synchronous instance
    logic mp1 [2], mn1 [2], mp2 [2], mn2 [2];
    logic m_eq [2], m_lvl [2], m_sig [2], m_psig [2];
    logic m_r [2], m_f [2], m_e [2];
    string phase_tag = "";

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            mp1[k] = 1'b0; mn1[k] = 1'b1; mp2[k] = 1'b0; mn2[k] = 1'b1;
            m_eq[k] = 1'b0; m_lvl[k] = 1'b0; m_sig[k] = 1'b0; m_psig[k] = 1'b0;
            m_r[k] = 1'b0; m_f[k] = 1'b0; m_e[k] = 1'b0;
        end
    endtask

    task automatic model_step(input int k, input logic ip, input logic in_);
        logic dp, dn, v, eq, flt, chg;
        if (k == 0) begin dp = mp2[k]; dn = mn2[k]; end
        else        begin dp = ip;     dn = in_;    end
        v   = dp ^ dn;
        eq  = ~v;
        flt = (k == 0) ? (eq & m_eq[k]) : eq;
        chg = v & (dp != m_lvl[k]) & ~m_sig[k];
        m_psig[k] = m_sig[k];
        m_r[k] = chg & dp;
        m_f[k] = chg & ~dp;
        m_e[k] = chg;
        if (v) m_lvl[k] = dp;
        m_sig[k] = flt;
        m_eq[k]  = eq;
        mp2[k] = mp1[k]; mn2[k] = mn1[k];
        mp1[k] = ip;     mn1[k] = in_;
    endtask

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic string pick(input string dflt);
        return (phase_tag != "") ? phase_tag : dflt;
    endfunction

    task automatic compare_all();
        string pt;
        // asynchronous instance
        pt = m_psig[0] ? "R8" : "R2";
        check(pick("R1"), "async level", a_lvl, m_lvl[0]);
        check(pick(pt), "async rise", a_rise, m_r[0]);
        check(pick(m_psig[0] ? "R8" : "R3"), "async fall", a_fall, m_f[0]);
        check(pick(m_psig[0] ? "R8" : "R4"), "async event", a_evt, m_e[0]);
        check(pick("R6"), "async sigint", a_sig, m_sig[0]);
        // synchronous instance
        pt = m_psig[1] ? "R8" : "R2";
        check(pick("R1"), "sync level", s_lvl, m_lvl[1]);
        check(pick(pt), "sync rise", s_rise, m_r[1]);
        check(pick(m_psig[1] ? "R8" : "R3"), "sync fall", s_fall, m_f[1]);
        check(pick(m_psig[1] ? "R8" : "R4"), "sync event", s_evt, m_e[1]);
        check(pick("R5"), "sync sigint", s_sig, m_sig[1]);
    endtask

    task automatic apply(input logic p, input logic n);
        in_p = p;
        in_n = n;
        @(posedge clk);
        model_step(0, p, n);
        model_step(1, p, n);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #400000;
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        phase_tag = "R9";
        compare_all();
        rst = 1'b0;
        phase_tag = "";

        // exhaustive sweep of all four-symbol sequences
        for (int a = 0; a < 256; a++) begin
            for (int d = 0; d < 4; d++) begin
                logic [1:0] sym;
                sym = 2'((a >> (2 * d)) & 3);
                apply(sym[1], sym[0]);
            end
        end

        // R7 skewed transitions: one wire moves a cycle before the other
        phase_tag = "R7";
        repeat (4) apply(1'b0, 1'b1);
        apply(1'b1, 1'b1);
        repeat (4) apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        repeat (4) apply(1'b0, 1'b1);

        // R8 sustained fault then recovery to a new level
        phase_tag = "R8";
        repeat (4) apply(1'b0, 0);
        repeat (4) apply(1'b1, 1'b0);
        repeat (4) apply(1'b1, 1'b1);
        repeat (4) apply(1'b0, 1'b1);
        phase_tag = "";

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule